// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a logical access falls inside one of the fixed address windows that bypass page translation. It holds four window registers: two serve instruction fetches and two serve data accesses. Each window register carries an enable bit, a privilege filter, an 8-bit base with an 8-bit don't-care mask that together cover the top address byte, a write-protect bit, and two attribute fields (cache mode and a user attribute) that are forwarded untouched to the caller.

The lookup is combinational. An access presents its address and whether it is a code fetch and whether it runs in supervisor mode. If a window of the matching space accepts it, the block reports a hit, returns the address unchanged as the physical address, and grants read and execute, plus write unless the window is write-protected. When both windows of a space accept, the lower-numbered one wins. A probe strobe that coincides with a hit records a fixed status word in a register on the next clock edge. Page-table walking belongs to another block and is not part of this one.

Top module: `tt_window_match`

## Requirements
- R1: A window register whose enable bit (bit 15) is 0 never matches, whatever its other fields hold.
- R2: The privilege filter in bits 14:13 admits only user accesses when 2'b00, only supervisor accesses when 2'b01, and every access when 2'b10 or 2'b11.
- R3: The address test uses only the top address byte: a window matches when (top ^ base) & ~mask is zero, base being bits 31:24 and mask bits 23:16; a mask bit of 1 makes that address bit don't-care, and address bits below the top byte never influence the result.
- R4: On a hit, grant_read and grant_exec are 1 and grant_write equals the inverse of the winning window's write-protect bit (bit 2); on a miss all three grants are 0.
- R5: A code fetch (acc_code=1) is tested only against entries 0 and 1; a data access (acc_code=0) only against entries 2 and 3.
- R6: When both windows of the selected space match, the lower-numbered one wins; hit_slot gives its position within the pair (0 or 1), and cache_mode (bits 6:5) and user_attr (bits 9:8) come from it; on a miss hit_slot, cache_mode and user_attr are 0.
- R7: On a hit phys_addr equals acc_addr in the same cycle; on a miss it is 0.
- R8: When acc_probe is 1 together with a hit at a rising clock edge, probe_status becomes 32'h0000_0003 after that edge (bit 1 marks a transparent hit, bit 0 marks the page resident), all other bits 0.
- R9: Reset clears probe_status and all four window registers; a probe that misses, or any cycle without a probe, leaves probe_status unchanged.
- R10: With cfg_we=1 at a rising edge, cfg_wdata is written into entry cfg_idx (0,1 instruction; 2,3 data) and governs lookups from the next cycle on, leaving the other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Entry written: 0,1 instruction, 2,3 data |
| cfg_wdata | input | 32 | Value written into the selected entry |
| acc_addr | input | 32 | Logical address of the access |
| acc_code | input | 1 | 1 for an instruction fetch, 0 for a data access |
| acc_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| acc_probe | input | 1 | Probe strobe; updates probe_status on a hit |
| hit | output | 1 | Access lies in an enabled window of its space |
| hit_slot | output | 1 | Position of the winning window within its pair |
| grant_read | output | 1 | Read permitted |
| grant_write | output | 1 | Write permitted |
| grant_exec | output | 1 | Execute permitted |
| phys_addr | output | 32 | Untranslated address on a hit, 0 on a miss |
| cache_mode | output | 2 | Cache mode field of the winning window |
| user_attr | output | 2 | User attribute field of the winning window |
| probe_status | output | 32 | Status word recorded by the last probe hit |

## Verification
Every lookup result (hit, slot, grants, address, attributes) is combinational and therefore due in the same cycle as the access, while a register write takes effect one edge later and a probe changes probe_status one edge later. The bench drives inputs just after a falling edge and samples one time unit later for lookups, so each configuration written at a rising edge is already in force; probe results are sampled at the falling edge that follows the rising edge on which the probe was held. Each configuration is swept over all 256 top-byte values and all four code/privilege combinations, with the low address bits varied to show they are ignored.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TTR_W   = 32;
  localparam int STAT_W  = 32;
  localparam int BYTE_W  = 8;

  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int SEL_LSB  = 13;
  localparam int UA_LSB   = 8;
  localparam int CM_LSB   = 5;
  localparam int WP_BIT   = 2;

  localparam int ST_RESIDENT    = 0;
  localparam int ST_TRANSPARENT = 1;

  typedef enum logic [1:0] {
    SEL_USER_ONLY  = 2'b00,
    SEL_SUPER_ONLY = 2'b01,
    SEL_ANY_A      = 2'b10,
    SEL_ANY_B      = 2'b11
  } priv_sel_e;

  function automatic logic win_enabled(input logic [TTR_W-1:0] w);
    return w[EN_BIT];
  endfunction

  function automatic logic win_priv_ok(input logic [TTR_W-1:0] w, input logic sup);
    priv_sel_e s;
    s = priv_sel_e'(w[SEL_LSB +: 2]);
    case (s)
      SEL_USER_ONLY:  return !sup;
      SEL_SUPER_ONLY: return sup;
      default:        return 1'b1;
    endcase
  endfunction

  function automatic logic win_addr_ok(input logic [TTR_W-1:0] w, input logic [BYTE_W-1:0] top);
    logic [BYTE_W-1:0] care;
    care = ~w[MASK_LSB +: BYTE_W];
    return ((top ^ w[BASE_LSB +: BYTE_W]) & care) == '0;
  endfunction

  function automatic logic [STAT_W-1:0] probe_hit_word();
    logic [STAT_W-1:0] v;
    v = '0;
    v[ST_RESIDENT]    = 1'b1;
    v[ST_TRANSPARENT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/tt_reg_bank.sv
module tt_reg_bank
  import tt_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TTR_W-1:0]            wdata,
  output logic [N_ENT-1:0][TTR_W-1:0] regs
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel_this;
    assign sel_this = we && (idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)        regs[e] <= '0;
      else if (sel_this) regs[e] <= wdata;
    end
  end
endmodule

// File: rtl/tt_entry_cmp.sv
module tt_entry_cmp
  import tt_pkg::*;
(
  input  logic [TTR_W-1:0]  ttr,
  input  logic [BYTE_W-1:0] addr_top,
  input  logic              is_super,
  output logic              match
);
  logic en_ok, priv_ok, addr_ok;
  assign en_ok   = win_enabled(ttr);
  assign priv_ok = win_priv_ok(ttr, is_super);
  assign addr_ok = win_addr_ok(ttr, addr_top);
  assign match   = en_ok && priv_ok && addr_ok;
endmodule

// File: rtl/tt_pick.sv
module tt_pick
  import tt_pkg::*;
#(
  parameter int N_PER = 2,
  localparam int N_ENT  = 2 * N_PER,
  localparam int SLOT_W = (N_PER > 1) ? $clog2(N_PER) : 1
) (
  input  logic [N_ENT-1:0]            match_vec,
  input  logic [N_ENT-1:0][TTR_W-1:0] regs,
  input  logic                        is_code,
  output logic                        hit,
  output logic [SLOT_W-1:0]           slot,
  output logic [TTR_W-1:0]            win
);
  always_comb begin
    int base;
    base = is_code ? 0 : N_PER;
    hit  = 1'b0;
    slot = '0;
    win  = '0;
    for (int k = N_PER - 1; k >= 0; k--) begin
      if (match_vec[base + k]) begin
        hit  = 1'b1;
        slot = SLOT_W'(k);
        win  = regs[base + k];
      end
    end
  end
endmodule

// File: rtl/tt_probe_status.sv
module tt_probe_status
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe,
  input  logic              hit,
  output logic [STAT_W-1:0] status
);
  logic capture;
  assign capture = probe && hit;
  always_ff @(posedge clk) begin
    if (!rst_n)       status <= '0;
    else if (capture) status <= probe_hit_word();
  end
endmodule

// File: rtl/tt_window_match.sv
module tt_window_match
  import tt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_PER  = 2,
  localparam int N_ENT  = 2 * N_PER,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int SLOT_W = (N_PER > 1) ? $clog2(N_PER) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [TTR_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_code,
  input  logic              acc_super,
  input  logic              acc_probe,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              grant_read,
  output logic              grant_write,
  output logic              grant_exec,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [1:0]        cache_mode,
  output logic [1:0]        user_attr,
  output logic [STAT_W-1:0] probe_status
);
  logic [N_ENT-1:0][TTR_W-1:0] ttr_q;
  logic [N_ENT-1:0]            match_vec;
  logic [BYTE_W-1:0]           addr_top;
  logic [TTR_W-1:0]            win_ttr;

  assign addr_top = acc_addr[ADDR_W-1 -: BYTE_W];

  tt_reg_bank #(.N_ENT(N_ENT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .regs(ttr_q)
  );

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    tt_entry_cmp u_cmp (
      .ttr(ttr_q[e]), .addr_top(addr_top), .is_super(acc_super),
      .match(match_vec[e])
    );
  end

  tt_pick #(.N_PER(N_PER)) u_pick (
    .match_vec(match_vec), .regs(ttr_q), .is_code(acc_code),
    .hit(hit), .slot(hit_slot), .win(win_ttr)
  );

  assign grant_read  = hit;
  assign grant_exec  = hit;
  assign grant_write = hit && !win_ttr[WP_BIT];
  assign phys_addr   = hit ? acc_addr : '0;
  assign cache_mode  = win_ttr[CM_LSB +: 2];
  assign user_attr   = win_ttr[UA_LSB +: 2];

  tt_probe_status u_stat (
    .clk(clk), .rst_n(rst_n), .probe(acc_probe), .hit(hit),
    .status(probe_status)
  );
endmodule

// File: rtl/tt_window_match_chk.sv
module tt_window_match_chk
  import tt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_PER  = 2,
  localparam int N_ENT = 2 * N_PER,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic [IDX_W-1:0]            cfg_idx,
  input logic [TTR_W-1:0]            cfg_wdata,
  input logic [ADDR_W-1:0]           acc_addr,
  input logic                        acc_code,
  input logic                        acc_super,
  input logic                        acc_probe,
  input logic                        hit,
  input logic                        grant_read,
  input logic                        grant_write,
  input logic                        grant_exec,
  input logic [ADDR_W-1:0]           phys_addr,
  input logic [STAT_W-1:0]           probe_status,
  input logic [N_ENT-1:0]            match_vec,
  input logic [N_ENT-1:0][TTR_W-1:0] ttr_q
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    AST_DISABLED_NEVER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[e] |-> ttr_q[e][EN_BIT]); // R1
    AST_SUPER_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vec[e] && ttr_q[e][SEL_LSB +: 2] == 2'b01) |-> acc_super); // R2
    AST_USER_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vec[e] && ttr_q[e][SEL_LSB +: 2] == 2'b00) |-> !acc_super); // R2
  end

  AST_MISS_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!grant_read && !grant_write && !grant_exec)); // R4
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_write |-> (grant_read && grant_exec)); // R4
  AST_SPACE_SEPARATION: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_code ? (|match_vec[N_PER-1:0]) : (|match_vec[N_ENT-1:N_PER]))); // R5
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (phys_addr == acc_addr)); // R7
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (phys_addr == '0)); // R7
  AST_PROBE_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_probe && hit) |=> (probe_status == 32'h3)); // R8
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_probe && hit) |=> $stable(probe_status)); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ttr_q[$past(cfg_idx)] == $past(cfg_wdata))); // R10
endmodule

bind tt_window_match tt_window_match_chk #(.ADDR_W(ADDR_W), .N_PER(N_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_code(acc_code),
  .acc_super(acc_super), .acc_probe(acc_probe), .hit(hit),
  .grant_read(grant_read), .grant_write(grant_write), .grant_exec(grant_exec),
  .phys_addr(phys_addr), .probe_status(probe_status),
  .match_vec(match_vec), .ttr_q(ttr_q)
);

// File: tb/tt_window_match_bench.sv
module tt_window_match_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_code = 1'b0;
  logic        acc_super = 1'b0;
  logic        acc_probe = 1'b0;
  logic        hit, hit_slot, grant_read, grant_write, grant_exec;
  logic [31:0] phys_addr, probe_status;
  logic [1:0]  cache_mode, user_attr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_window_match u_tt_window_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_code(acc_code),
    .acc_super(acc_super), .acc_probe(acc_probe), .hit(hit),
    .hit_slot(hit_slot), .grant_read(grant_read), .grant_write(grant_write),
    .grant_exec(grant_exec), .phys_addr(phys_addr), .cache_mode(cache_mode),
    .user_attr(user_attr), .probe_status(probe_status)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] base, input logic [7:0] msk,
      input logic en, input logic [1:0] sel, input logic [1:0] ua,
      input logic [1:0] cm, input logic wp);
    return {base, msk, en, sel, 3'b000, ua, 1'b0, cm, 2'b00, wp, 2'b00};
  endfunction

  // Bench model: bit-by-bit address test, explicit privilege table
  function automatic bit ent_hits(input logic [31:0] w, input logic [7:0] top, input logic sup);
    bit ok;
    ok = w[15];
    if (w[14:13] == 2'b00 && sup)  ok = 0;
    if (w[14:13] == 2'b01 && !sup) ok = 0;
    for (int b = 0; b < 8; b++)
      if (!w[16+b] && (top[b] != w[24+b])) ok = 0;
    return ok;
  endfunction

  task automatic wr(input int idx, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    model[idx] = v;
  endtask

  task automatic sweep(input string tag);
    for (int t = 0; t < 256; t++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] a;
        bit eh; bit es; logic [31:0] ew;
        int first;
        a = {t[7:0], t[7:0] ^ 8'h5A, ~t[7:0], 8'(m * 37)};
        @(negedge clk);
        acc_addr = a; acc_code = m[0]; acc_super = m[1];
        #1;
        first = m[0] ? 0 : 2;
        eh = 0; es = 0; ew = '0;
        for (int k = 1; k >= 0; k--)
          if (ent_hits(model[first + k], t[7:0], m[1])) begin
            eh = 1; es = k[0]; ew = model[first + k];
          end
        chk({31'b0, hit}, {31'b0, eh}, {tag, " R1,R2,R3,R5 hit"});
        chk({29'b0, grant_read, grant_exec, grant_write},
            {29'b0, eh, eh, eh & !ew[2]}, {tag, " R4 grants"});
        chk(phys_addr, eh ? a : 32'h0, {tag, " R7 phys_addr"});
        chk({27'b0, hit_slot, cache_mode, user_attr},
            {27'b0, es, ew[6:5], ew[9:8]}, {tag, " R6 slot/attrs"});
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(probe_status, 32'h0, "R9 reset status");
    sweep("reset");

    // Config A: overlapping instruction windows, filtered data window, disabled catch-all
    wr(0, mk(8'h40, 8'h0F, 1, 2'b10, 2'b11, 2'b01, 0));
    wr(1, mk(8'h40, 8'h00, 1, 2'b00, 2'b01, 2'b10, 1));
    wr(2, mk(8'h80, 8'h7F, 1, 2'b01, 2'b10, 2'b11, 1));
    wr(3, mk(8'h00, 8'hFF, 0, 2'b11, 2'b11, 2'b11, 0));
    sweep("cfgA");
    chk(probe_status, 32'h0, "R9 status untouched without probe");

    // Probe miss then probe hit then probe miss
    @(negedge clk);
    acc_addr = 32'h2000_0000; acc_code = 1; acc_super = 1; acc_probe = 1;
    @(negedge clk);
    chk(probe_status, 32'h0, "R9 probe miss keeps status");
    acc_addr = 32'h4312_3456;
    @(negedge clk);
    chk(probe_status, 32'h3, "R8 probe hit status");
    acc_addr = 32'h2000_0000;
    @(negedge clk);
    chk(probe_status, 32'h3, "R9 probe miss after hit keeps status");
    acc_probe = 0;

    // Config B: rewrite entries; one-entry write leaves the others
    wr(3, mk(8'hC3, 8'hFF, 1, 2'b11, 2'b10, 2'b01, 0));
    sweep("cfgB R10");
    wr(0, mk(8'hA5, 8'h00, 0, 2'b10, 2'b01, 2'b01, 0));
    wr(1, mk(8'hFF, 8'h00, 1, 2'b01, 2'b11, 2'b00, 0));
    wr(2, mk(8'h15, 8'hA0, 1, 2'b00, 2'b01, 2'b10, 0));
    sweep("cfgC");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule